// File: doc/BRIEF.md
# Circular Descriptor Ring Index Tracker

This block keeps the bookkeeping for one circular ring of transfer descriptors shared by a producer and a consumer. The producer is software. It reaches the block through a small register write port. With that port it can program the ring size, load the producer (write) index directly, or post one new entry at a time. The consumer is the transfer engine. It pulses a completion strobe each time it finishes the descriptor at the consumer (read) index, and that index then moves forward by one.

The ring size is a power of two, and every index wraps by masking with size minus one. One slot is always left unused, so a full ring and an empty ring can be told apart. From the two indices the block derives:
- the occupancy;
- empty and full flags;
- two watermark flags, compared against thresholds packed into one register.

A separate register keeps the per-transfer maximum length and two byte-swap enables (source side, destination side). These are passed straight to the engine.

Top module: `ring_index_ctrl`

## Requirements
- R1: After reset both indices are 0, the ring size is 2^MAX_LOG2, the low threshold is 0, the high threshold equals the ring size, and the maximum length and both swap enables are 0.
- R2: A write to address 0 sets the ring size and zeroes both indices. It is accepted only if the value is a power of two between 2 and 2^MAX_LOG2. Any other value changes nothing. An accepted size write takes precedence over a completion strobe in the same cycle.
- R3: A write to address 1 loads the write index with the written value ANDed with size minus one.
- R4: A write to address 2 (post) advances the write index by one modulo the size, but only while the ring is not full. A post to a full ring changes nothing.
- R5: Each cycle with `done` high advances the read index by one modulo the size, unless the ring is empty. The empty test uses the indices as they were before that cycle.
- R6: `occupancy` equals (write index − read index) AND (size − 1). `empty` is high exactly when the two indices are equal.
- R7: `full` is high exactly when (read index − 1 − write index) AND (size − 1) is zero, so at most size − 1 entries are ever held.
- R8: A write to address 3 sets the low threshold from data bits [15:0] and the high threshold from bits [31:16]; each field is truncated to MAX_LOG2+1 bits. `hi_mark` is high when occupancy ≥ high threshold. `lo_mark` is high when occupancy ≤ low threshold.
- R9: A write to address 4 sets only the maximum length, from bits [LEN_W-1:0]. A write to address 5 sets only the swap enables: bit 0 for the source side, bit 1 for the destination side.
- R10: Writes to addresses 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| we | input | 1 | Register write strobe |
| waddr | input | AW | Register write address |
| wdata | input | DW | Register write data |
| done | input | 1 | Descriptor completion strobe from the engine |
| rd_idx | output | MAX_LOG2 | Consumer (read) index |
| wr_idx | output | MAX_LOG2 | Producer (write) index |
| occupancy | output | MAX_LOG2 | Entries currently held |
| empty | output | 1 | Ring holds no entries |
| full | output | 1 | Ring holds size − 1 entries |
| hi_mark | output | 1 | Occupancy at or above the high threshold |
| lo_mark | output | 1 | Occupancy at or below the low threshold |
| max_len | output | LEN_W | Maximum transfer length field |
| swap_src | output | 1 | Source-side byte-swap enable |
| swap_dst | output | 1 | Destination-side byte-swap enable |

## Verification
The bench builds the block with MAX_LOG2 = 4, so the largest ring has 16 slots. At that size a run reaches full, empty and index wrap-around many times, and it can also resize the ring down to 4 and 2 slots. The data word stays 32 bits wide, which keeps the two 16-bit watermark fields and the out-of-range size values (0, 1, 3, 32) within reach of directed writes. A long pseudo-random phase then mixes posts, direct index loads, completions and resizes against the reference model.

// File: rtl/ring_index_ctrl.sv
module ring_index_ctrl #(
  parameter int DW       = 32,
  parameter int AW       = 3,
  parameter int MAX_LOG2 = 10,
  parameter int LEN_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic                done,
  output logic [MAX_LOG2-1:0] rd_idx,
  output logic [MAX_LOG2-1:0] wr_idx,
  output logic [MAX_LOG2-1:0] occupancy,
  output logic                empty,
  output logic                full,
  output logic                hi_mark,
  output logic                lo_mark,
  output logic [LEN_W-1:0]    max_len,
  output logic                swap_src,
  output logic                swap_dst
);
  localparam int IW = MAX_LOG2;
  localparam int SW = MAX_LOG2 + 1;
  localparam logic [SW-1:0] SIZE_MAX = SW'(1) << MAX_LOG2;
  localparam logic [AW-1:0] A_SIZE = AW'(0);
  localparam logic [AW-1:0] A_PROD = AW'(1);
  localparam logic [AW-1:0] A_POST = AW'(2);
  localparam logic [AW-1:0] A_MARK = AW'(3);
  localparam logic [AW-1:0] A_LEN  = AW'(4);
  localparam logic [AW-1:0] A_SWAP = AW'(5);

  logic [SW-1:0] size_q, lo_q, hi_q;
  logic [IW-1:0] rd_q, wr_q, mask, free_cnt;
  logic [LEN_W-1:0] len_q;
  logic [1:0] swap_q;
  logic size_ok, wr_size;

  assign mask     = IW'(size_q - SW'(1));
  assign size_ok  = (wdata >= DW'(2)) && (wdata <= DW'(SIZE_MAX)) &&
                    ((wdata & (wdata - DW'(1))) == '0);
  assign wr_size  = we && (waddr == A_SIZE) && size_ok;
  assign occupancy = (wr_q - rd_q) & mask;
  assign free_cnt  = (rd_q - IW'(1) - wr_q) & mask;
  assign empty    = (rd_q == wr_q);
  assign full     = (free_cnt == '0);
  assign hi_mark  = {1'b0, occupancy} >= hi_q;
  assign lo_mark  = {1'b0, occupancy} <= lo_q;
  assign rd_idx   = rd_q;
  assign wr_idx   = wr_q;
  assign max_len  = len_q;
  assign swap_src = swap_q[0];
  assign swap_dst = swap_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_MAX;
      rd_q   <= '0;
      wr_q   <= '0;
    end else if (wr_size) begin
      size_q <= wdata[SW-1:0];
      rd_q   <= '0;
      wr_q   <= '0;
    end else begin
      if (done && !empty)
        rd_q <= (rd_q + IW'(1)) & mask;
      if (we && waddr == A_PROD)
        wr_q <= wdata[IW-1:0] & mask;
      else if (we && waddr == A_POST && !full)
        wr_q <= (wr_q + IW'(1)) & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= SIZE_MAX;
      len_q  <= '0;
      swap_q <= '0;
    end else if (we) begin
      case (waddr)
        A_MARK: begin
          lo_q <= wdata[SW-1:0];
          hi_q <= wdata[16+SW-1:16];
        end
        A_LEN:  len_q  <= wdata[LEN_W-1:0];
        A_SWAP: swap_q <= wdata[1:0];
        default: ;
      endcase
    end
  end

  p_bad_size_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == A_SIZE && !size_ok) |=> $stable(size_q));
  p_size_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_size |=> (rd_idx == '0 && wr_idx == '0));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == A_POST && full) |=> $stable(wr_idx));
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && empty && !(we && (waddr == A_SIZE || waddr == A_PROD))) |=> $stable(rd_idx));
  p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  p_read_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !empty && !wr_size) |=> (rd_idx != $past(rd_idx)));
endmodule

// File: tb/ring_index_ctrl_tb.sv
module ring_index_ctrl_tb;
  localparam int DW = 32, AW = 3, ML = 4, LW = 16;
  localparam int SMAX = 1 << ML;

  logic clk = 0, rst_n = 0, we = 0, done = 0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [ML-1:0] rd_idx, wr_idx, occupancy;
  logic empty, full, hi_mark, lo_mark, swap_src, swap_dst;
  logic [LW-1:0] max_len;

  ring_index_ctrl #(.DW(DW), .AW(AW), .MAX_LOG2(ML), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata), .done(done),
    .rd_idx(rd_idx), .wr_idx(wr_idx), .occupancy(occupancy), .empty(empty),
    .full(full), .hi_mark(hi_mark), .lo_mark(lo_mark), .max_len(max_len),
    .swap_src(swap_src), .swap_dst(swap_dst));

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  int m_sz, m_rd, m_wr, m_lo, m_hi, m_len, m_sw;
  int lcg = 12345;

  function automatic int occ_m();
    return (m_wr - m_rd) & (m_sz - 1);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    int o = occ_m();
    vecs++;
    cmp("R5", "rd_idx", rd_idx, m_rd);
    cmp("R3/R4", "wr_idx", wr_idx, m_wr);
    cmp("R6", "occupancy", occupancy, o);
    cmp("R6", "empty", empty, m_rd == m_wr);
    cmp("R7", "full", full, ((m_rd - 1 - m_wr) & (m_sz - 1)) == 0);
    cmp("R8", "hi_mark", hi_mark, o >= m_hi);
    cmp("R8", "lo_mark", lo_mark, o <= m_lo);
    cmp("R9", "max_len", max_len, m_len);
    cmp("R9", "swap", {30'd0, swap_dst, swap_src}, m_sw);
  endtask

  task automatic step(bit w, int a, int d, bit c);
    int full_m, empty_m, mask;
    bit ok;
    we = w; waddr = AW'(a); wdata = DW'(d); done = c;
    @(posedge clk);
    mask = m_sz - 1;
    full_m = (((m_rd - 1 - m_wr) & mask) == 0);
    empty_m = (m_rd == m_wr);
    ok = (d >= 2) && (d <= SMAX) && ((d & (d - 1)) == 0);
    if (w && a == 0 && ok) begin
      m_sz = d; m_rd = 0; m_wr = 0;
    end else begin
      if (c && !empty_m) m_rd = (m_rd + 1) & mask;
      if (w && a == 1) m_wr = d & mask;
      else if (w && a == 2 && !full_m) m_wr = (m_wr + 1) & mask;
    end
    if (w && a == 3) begin m_lo = d & (2*SMAX - 1); m_hi = (d >> 16) & (2*SMAX - 1); end
    if (w && a == 4) m_len = d & 16'hFFFF;
    if (w && a == 5) m_sw = d & 3;
    @(negedge clk);
    we = 0; done = 0;
    check_all();
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    m_sz = SMAX; m_rd = 0; m_wr = 0; m_lo = 0; m_hi = SMAX; m_len = 0; m_sw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all(); // R1 reset state
    step(1, 3, (5 << 16) | 2, 0);        // R8 thresholds low 2, high 5
    for (int i = 0; i < 17; i++) step(1, 2, 0, 0); // R4 fill to full, extra posts ignored
    for (int i = 0; i < 17; i++) step(0, 0, 0, 1); // R5 drain, extra strobes ignored
    step(1, 0, 3, 0);  // R2 invalid sizes
    step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    step(1, 0, 32, 0);
    step(1, 1, 7, 0);  // R3
    step(1, 0, 4, 1);  // R2 size wins over completion
    step(1, 1, 32'h13, 0); // R3 masking: 3
    for (int i = 0; i < 10; i++) begin
      step(1, 2, 0, 1); // R4 with R5 concurrent, wrap
    end
    step(1, 4, 32'hABCD_1234, 0); // R9
    step(1, 5, 32'hFFFF_FFFE, 0); // R9
    step(1, 6, 32'hFFFF_FFFF, 1); // R10
    step(1, 7, 32'h0000_0002, 0); // R10
    step(1, 0, 2, 0);  // R2 minimum size
    step(1, 2, 0, 0);
    step(1, 2, 0, 0);
    step(1, 0, 16, 0);
    for (int i = 0; i < 2000; i++) begin
      int a, d;
      lcg = lcg * 1103515245 + 12345;
      a = (lcg >>> 16) & 7;
      d = (lcg >>> 8) & 32'h1F;
      if (a == 3) d = ((lcg >>> 4) & 32'h1F) << 16 | d;
      if (a == 0 && ((lcg >>> 20) & 3) != 0) a = 2;
      step(((lcg >>> 24) & 3) != 0, a, d, ((lcg >>> 27) & 1) == 1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule